// File: doc/BRIEF.md
# USB LPM L1 Sleep Controller

This block puts a USB 2.0 port into the L1 low-power sleep state and brings it back out. It keeps the last decoded LPM handshake outcome in a two-bit status field, raises a dedicated sleep-status flag when an acknowledged LPM transaction takes the port to sleep, and drives the PHY suspend and deep-low-power controls while the port is asleep. Packet decoding and token handling happen elsewhere. The handshake arrives as a strobe with an already decoded two-bit code.

The port leaves sleep on line-state activity, a write of the remote-wakeup control bit, a bus reset or a soft disconnect. In host role, line activity means the attached device has started a resume. The block then drives resume signaling for a time set by a four-bit code in a five-bit threshold field. Bit 4 of that field allows deep-low-power mode. Time is measured with a prescaler of `TICKS_PER_US` reference clocks per microsecond.

Each exit follows a fixed order. First the PHY controls drop. One cycle later the sleep flag clears, and in that same cycle a one-cycle wake-done strobe fires.

Top module: `lpm_l1_ctrl`

## Requirements
- R1: In reset (synchronous, active-low), the handshake result and threshold fields read zero. The sleep flag, the PHY controls, the resume drive, the wake strobe and the error flag are all low.
- R2: A cycle with `hs_valid_i` high stores `hs_code_i` into `hs_result_o`, visible on the next cycle. The codes are 2'b11 ACK, 2'b10 NYET, 2'b01 STALL and 2'b00 no response.
- R3: From the awake state, only an ACK handshake (2'b11) sets `sleep_sts_o`, one cycle after the strobe. NYET, STALL and no-response leave it low.
- R4: `phy_suspend_o` is high only while the port is asleep (not resuming or waking) and `clk_stop_i` is high.
- R5: `phy_deep_lp_o` is high only while `phy_suspend_o` is high, `host_mode_i` is 1 and threshold bit 4 is 1.
- R6: While asleep, any one of `line_active_i`, `rwk_wr_i`, `bus_reset_i` or `soft_disc_i` starts the exit. `rwk_wr_i`, `bus_reset_i` and `soft_disc_i` take precedence over line activity.
- R7: Exit order is fixed. In the first cycle the PHY controls are low and `sleep_sts_o` is still high. In the next cycle `sleep_sts_o` is low and `wake_done_o` is high for exactly one cycle.
- R8: In host role with threshold bits [3:0] = c and c ≤ 12, line activity during sleep holds `resume_drive_o` high for exactly (60 + 75·c)·`TICKS_PER_US` cycles. `sleep_sts_o` stays high throughout, and the R7 exit follows.
- R9: In host role with c in 13..15, line activity does not drive resume. It sets the sticky `thres_err_o` and goes straight to the R7 exit. A threshold write clears `thres_err_o`.
- R10: An ACK handshake that arrives while resume signaling or the exit sequence is in progress does not put the port back to sleep.
- R11: In device role, line activity during sleep never drives resume and never sets `thres_err_o`. The port goes straight to the R7 exit.
- R12: A bus reset or soft disconnect during resume signaling ends the resume drive on the next cycle and enters the R7 exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_mode_i | input | 1 | 1 = host role, 0 = device role |
| thres_wr_i | input | 1 | Write strobe for the threshold field |
| thres_in_i | input | 5 | Threshold value to write: bit 4 deep enable, [3:0] resume code |
| hs_valid_i | input | 1 | Decoded LPM handshake strobe |
| hs_code_i | input | 2 | Decoded handshake code |
| clk_stop_i | input | 1 | Port clock stop control bit |
| line_active_i | input | 1 | Activity seen on the USB line state |
| rwk_wr_i | input | 1 | Write of the remote-wakeup signaling bit |
| bus_reset_i | input | 1 | USB bus reset |
| soft_disc_i | input | 1 | Soft disconnect |
| hs_result_o | output | 2 | Stored handshake outcome |
| thres_o | output | 5 | Current threshold field |
| sleep_sts_o | output | 1 | Port is in L1 sleep |
| phy_suspend_o | output | 1 | PHY suspend control |
| phy_deep_lp_o | output | 1 | PHY deep-low-power control |
| resume_drive_o | output | 1 | Host resume signaling active |
| wake_done_o | output | 1 | One-cycle strobe when the exit completes |
| thres_err_o | output | 1 | Sticky flag: resume attempted with an invalid code |

## Verification
The bench sweeps all sixteen resume codes in host role and counts resume-drive cycles against 60 + 75·code microseconds. An off-by-one in the prescaler or the microsecond counter would show as a count that is short or long by one tick or one microsecond. Codes 13 to 15 are checked to give no resume drive and a set error flag, so a design that compares against the wrong limit would either drive resume too long or wrongly reject code 12. Every exit event is checked cycle by cycle for the suspend-drop, flag-clear, strobe order, so a design that clears the flag together with the suspend control, or holds the strobe for two cycles, fails. The remaining cases are an ACK during resume, a bus reset part way through a resume, and line activity in device role with an invalid code. These catch re-entry into sleep, a resume that cannot be aborted, and error flagging in the wrong role.

// File: rtl/lpm_pkg.sv
// Package: shared types and helpers for the LPM L1 sleep controller.
// Assumes: the resume code is 4 bits and the resume time in microseconds fits in 10 bits.
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE  = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_RESUME = 3'd2,
        ST_DROP   = 3'd3,
        ST_DONE   = 3'd4
    } lpm_state_e;

    localparam logic [1:0] HS_ACK   = 2'b11;
    localparam logic [1:0] HS_NYET  = 2'b10;
    localparam logic [1:0] HS_STALL = 2'b01;
    localparam logic [1:0] HS_NONE  = 2'b00;

    localparam int RES_BASE_US = 60;
    localparam int RES_STEP_US = 75;
    localparam logic [3:0] RES_CODE_MAX = 4'd12;

    // Returns the resume drive length in microseconds, minus one, for a valid code.
    function automatic logic [9:0] resume_len_m1(input logic [3:0] code);
        logic [9:0] us;
        us = 10'(RES_BASE_US) + 10'(RES_STEP_US) * {6'd0, code};
        return us - 10'd1;
    endfunction

endpackage

// File: rtl/lpm_status_regs.sv
// Module: holds the threshold field, the stored handshake result and the
// sticky invalid-code error flag.
// Assumes: strobes last one cycle. A write clears the error flag, and the write
// takes priority if an error is raised in the same cycle.
module lpm_status_regs #(
    parameter int THR_W = 5,
    parameter int HS_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thres_wr,
    input  logic [THR_W-1:0] thres_in,
    input  logic             hs_valid,
    input  logic [HS_W-1:0]  hs_code,
    input  logic             err_set,
    output logic [THR_W-1:0] thres_q,
    output logic [HS_W-1:0]  hs_q,
    output logic             err_q
);

    // Threshold field register.
    always_ff @(posedge clk) begin
        if (!rst_n)        thres_q <= '0;
        else if (thres_wr) thres_q <= thres_in;
    end

    // Latest handshake outcome.
    always_ff @(posedge clk) begin
        if (!rst_n)        hs_q <= '0;
        else if (hs_valid) hs_q <= hs_code;
    end

    // Sticky invalid-code flag: a threshold write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (thres_wr) err_q <= 1'b0;
        else if (err_set)  err_q <= 1'b1;
    end

endmodule

// File: rtl/lpm_resume_timer.sv
// Module: times host resume signaling in whole microseconds.
// Assumes: `load` fires one cycle before `run` rises. `run` stays high for
// the whole resume. `done` is high in the last cycle of the window, which
// lasts exactly (len_m1+1)*TICKS_PER_US cycles.
module lpm_resume_timer #(
    parameter int TICKS_PER_US = 60,
    parameter int US_W         = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [3:0] code,
    input  logic       run,
    output logic       done
);
    import lpm_pkg::*;

    localparam int PS_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICKS_PER_US - 1);

    logic [PS_W-1:0] ps_q;
    logic [US_W-1:0] us_q;
    logic [US_W-1:0] tgt_q;
    logic            ps_last;

    assign ps_last = (ps_q == PS_LAST);

    // Captures the target length when the resume begins.
    always_ff @(posedge clk) begin
        if (!rst_n)    tgt_q <= '0;
        else if (load) tgt_q <= US_W'(resume_len_m1(code));
    end

    // Prescaler and microsecond counter, both held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ps_q <= '0;
            us_q <= '0;
        end else if (ps_last) begin
            ps_q <= '0;
            us_q <= us_q + 1'b1;
        end else begin
            ps_q <= ps_q + 1'b1;
        end
    end

    // Marks the final cycle of the resume window.
    always_comb done = run && ps_last && (us_q == tgt_q);

endmodule

// File: rtl/lpm_sleep_fsm.sv
// Module: L1 sleep state machine and its PHY and status outputs.
// Assumes: event inputs are level or strobe, sampled every cycle. Bus reset,
// soft disconnect and remote wakeup take priority over line activity.
module lpm_sleep_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_mode,
    input  logic       hs_valid,
    input  logic [1:0] hs_code,
    input  logic [4:0] thres,
    input  logic       clk_stop,
    input  logic       line_active,
    input  logic       rwk_wr,
    input  logic       bus_reset,
    input  logic       soft_disc,
    input  logic       tmr_done,
    output logic       tmr_load,
    output logic       tmr_run,
    output logic       err_set,
    output logic       sleep_sts,
    output logic       phy_suspend,
    output logic       phy_deep_lp,
    output logic       resume_drive,
    output logic       wake_done
);
    import lpm_pkg::*;

    lpm_state_e st_q, st_d;
    logic       hard_exit;
    logic       code_ok;
    logic       dev_resume;

    assign hard_exit  = bus_reset || soft_disc;
    assign code_ok    = (thres[3:0] <= RES_CODE_MAX);
    assign dev_resume = (st_q == ST_SLEEP) && !hard_exit && !rwk_wr
                        && line_active && host_mode;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_AWAKE;
        else        st_q <= st_d;
    end

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_AWAKE:  if (hs_valid && hs_code == HS_ACK) st_d = ST_SLEEP;
            ST_SLEEP: begin
                if (hard_exit || rwk_wr)      st_d = ST_DROP;
                else if (line_active)         st_d = (host_mode && code_ok) ? ST_RESUME : ST_DROP;
            end
            ST_RESUME: if (hard_exit || tmr_done) st_d = ST_DROP;
            ST_DROP:   st_d = ST_DONE;
            ST_DONE:   st_d = ST_AWAKE;
            default:   st_d = ST_AWAKE;
        endcase
    end

    // Timer control and error reporting for device-initiated resume.
    always_comb begin
        tmr_load = dev_resume && code_ok;
        err_set  = dev_resume && !code_ok;
        tmr_run  = (st_q == ST_RESUME);
    end

    // Status and PHY outputs, decoded from the state.
    always_comb begin
        sleep_sts    = (st_q == ST_SLEEP) || (st_q == ST_RESUME) || (st_q == ST_DROP);
        phy_suspend  = (st_q == ST_SLEEP) && clk_stop;
        phy_deep_lp  = phy_suspend && host_mode && thres[4];
        resume_drive = (st_q == ST_RESUME);
        wake_done    = (st_q == ST_DONE);
    end

endmodule

// File: rtl/lpm_l1_ctrl.sv
// Module: top of the USB LPM L1 sleep controller.
// Assumes: one reference clock. All inputs are synchronous to it.
// TICKS_PER_US reference cycles make one microsecond.
module lpm_l1_ctrl #(
    parameter int TICKS_PER_US = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_mode_i,
    input  logic       thres_wr_i,
    input  logic [4:0] thres_in_i,
    input  logic       hs_valid_i,
    input  logic [1:0] hs_code_i,
    input  logic       clk_stop_i,
    input  logic       line_active_i,
    input  logic       rwk_wr_i,
    input  logic       bus_reset_i,
    input  logic       soft_disc_i,
    output logic [1:0] hs_result_o,
    output logic [4:0] thres_o,
    output logic       sleep_sts_o,
    output logic       phy_suspend_o,
    output logic       phy_deep_lp_o,
    output logic       resume_drive_o,
    output logic       wake_done_o,
    output logic       thres_err_o
);

    localparam int THR_W = 5;
    localparam int HS_W  = 2;
    localparam int US_W  = 10;

    logic tmr_load, tmr_run, tmr_done, err_set;

    lpm_status_regs #(.THR_W(THR_W), .HS_W(HS_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .thres_wr (thres_wr_i),
        .thres_in (thres_in_i),
        .hs_valid (hs_valid_i),
        .hs_code  (hs_code_i),
        .err_set  (err_set),
        .thres_q  (thres_o),
        .hs_q     (hs_result_o),
        .err_q    (thres_err_o)
    );

    lpm_resume_timer #(.TICKS_PER_US(TICKS_PER_US), .US_W(US_W)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .code  (thres_o[3:0]),
        .run   (tmr_run),
        .done  (tmr_done)
    );

    lpm_sleep_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_mode    (host_mode_i),
        .hs_valid     (hs_valid_i),
        .hs_code      (hs_code_i),
        .thres        (thres_o),
        .clk_stop     (clk_stop_i),
        .line_active  (line_active_i),
        .rwk_wr       (rwk_wr_i),
        .bus_reset    (bus_reset_i),
        .soft_disc    (soft_disc_i),
        .tmr_done     (tmr_done),
        .tmr_load     (tmr_load),
        .tmr_run      (tmr_run),
        .err_set      (err_set),
        .sleep_sts    (sleep_sts_o),
        .phy_suspend  (phy_suspend_o),
        .phy_deep_lp  (phy_deep_lp_o),
        .resume_drive (resume_drive_o),
        .wake_done    (wake_done_o)
    );

endmodule

// File: rtl/lpm_l1_ctrl_chk.sv
// Module: checker for lpm_l1_ctrl. It watches the top-level ports only and is
// attached to every instance with bind.
module lpm_l1_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_mode_i,
    input logic       hs_valid_i,
    input logic [1:0] hs_code_i,
    input logic       clk_stop_i,
    input logic [1:0] hs_result_o,
    input logic [4:0] thres_o,
    input logic       sleep_sts_o,
    input logic       phy_suspend_o,
    input logic       phy_deep_lp_o,
    input logic       resume_drive_o,
    input logic       wake_done_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (hs_result_o == 2'b00 && thres_o == 5'd0 && !sleep_sts_o && !wake_done_o)); // R1

    AST_HS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid_i |=> (hs_result_o == $past(hs_code_i))); // R2

    AST_SUSP_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        phy_suspend_o |-> (sleep_sts_o && clk_stop_i && !resume_drive_o)); // R4

    AST_DEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        phy_deep_lp_o |-> (phy_suspend_o && host_mode_i && thres_o[4])); // R5

    AST_WAKE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_done_o) |-> (!sleep_sts_o && $fell(sleep_sts_o))); // R7

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done_o |=> !wake_done_o); // R7

    AST_RESUME_HOLDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        resume_drive_o |-> (sleep_sts_o && !phy_suspend_o && host_mode_i)); // R8

    AST_RESUME_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_drive_o) |-> ($past(thres_o[3:0]) <= 4'd12)); // R9

endmodule

bind lpm_l1_ctrl lpm_l1_ctrl_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_mode_i    (host_mode_i),
    .hs_valid_i     (hs_valid_i),
    .hs_code_i      (hs_code_i),
    .clk_stop_i     (clk_stop_i),
    .hs_result_o    (hs_result_o),
    .thres_o        (thres_o),
    .sleep_sts_o    (sleep_sts_o),
    .phy_suspend_o  (phy_suspend_o),
    .phy_deep_lp_o  (phy_deep_lp_o),
    .resume_drive_o (resume_drive_o),
    .wake_done_o    (wake_done_o)
);

// File: tb/lpm_l1_ctrl_tb_top.sv
module lpm_l1_ctrl_tb_top;

    localparam int TPU = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_mode_i = 1'b0;
    logic       thres_wr_i = 1'b0;
    logic [4:0] thres_in_i = '0;
    logic       hs_valid_i = 1'b0;
    logic [1:0] hs_code_i = '0;
    logic       clk_stop_i = 1'b0;
    logic       line_active_i = 1'b0;
    logic       rwk_wr_i = 1'b0;
    logic       bus_reset_i = 1'b0;
    logic       soft_disc_i = 1'b0;
    logic [1:0] hs_result_o;
    logic [4:0] thres_o;
    logic       sleep_sts_o, phy_suspend_o, phy_deep_lp_o;
    logic       resume_drive_o, wake_done_o, thres_err_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lpm_l1_ctrl #(.TICKS_PER_US(TPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_mode_i(host_mode_i),
        .thres_wr_i(thres_wr_i), .thres_in_i(thres_in_i),
        .hs_valid_i(hs_valid_i), .hs_code_i(hs_code_i),
        .clk_stop_i(clk_stop_i), .line_active_i(line_active_i),
        .rwk_wr_i(rwk_wr_i), .bus_reset_i(bus_reset_i), .soft_disc_i(soft_disc_i),
        .hs_result_o(hs_result_o), .thres_o(thres_o), .sleep_sts_o(sleep_sts_o),
        .phy_suspend_o(phy_suspend_o), .phy_deep_lp_o(phy_deep_lp_o),
        .resume_drive_o(resume_drive_o), .wake_done_o(wake_done_o),
        .thres_err_o(thres_err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_thres(input logic [4:0] v);
        @(negedge clk); thres_wr_i = 1'b1; thres_in_i = v;
        @(negedge clk); thres_wr_i = 1'b0;
    endtask

    task automatic send_hs(input logic [1:0] c);
        @(negedge clk); hs_valid_i = 1'b1; hs_code_i = c;
        @(negedge clk); hs_valid_i = 1'b0;
    endtask

    // kind: 0 line activity, 1 remote wakeup write, 2 bus reset, 3 soft disconnect
    task automatic exit_event(input int kind);
        @(negedge clk);
        line_active_i = (kind == 0);
        rwk_wr_i      = (kind == 1);
        bus_reset_i   = (kind == 2);
        soft_disc_i   = (kind == 3);
        @(negedge clk);
        line_active_i = 1'b0; rwk_wr_i = 1'b0; bus_reset_i = 1'b0; soft_disc_i = 1'b0;
    endtask

    // Called at the negedge where the first exit cycle should be visible.
    task automatic wake_tail(input string req);
        check({req, " R7 drop: suspend"}, int'(phy_suspend_o), 0);
        check({req, " R7 drop: sleep still set"}, int'(sleep_sts_o), 1);
        check({req, " R7 drop: no strobe yet"}, int'(wake_done_o), 0);
        tick();
        check({req, " R7 done: sleep cleared"}, int'(sleep_sts_o), 0);
        check({req, " R7 done: strobe"}, int'(wake_done_o), 1);
        tick();
        check({req, " R7 after: strobe one cycle"}, int'(wake_done_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        check("R1 hs_result", int'(hs_result_o), 0);
        check("R1 thres", int'(thres_o), 0);
        check("R1 sleep", int'(sleep_sts_o), 0);
        check("R1 phy ctrl", int'({phy_suspend_o, phy_deep_lp_o, resume_drive_o}), 0);
        check("R1 strobe/err", int'({wake_done_o, thres_err_o}), 0);
        rst_n = 1'b1;
        tick();

        // R2, R3: every handshake code in both roles
        for (int h = 0; h < 2; h++) begin
            host_mode_i = h[0];
            for (int c = 0; c < 4; c++) begin
                send_hs(2'(c));
                check("R2 hs_result", int'(hs_result_o), c);
                check("R3 sleep only on ACK", int'(sleep_sts_o), (c == 3) ? 1 : 0);
                if (c == 3) begin
                    exit_event(2);
                    wake_tail("R6 bus reset");
                end
            end
        end

        // R4, R5, R6: suspend/deep gating and each exit event
        for (int h = 0; h < 2; h++) begin
            for (int b = 0; b < 2; b++) begin
                host_mode_i = h[0];
                write_thres({b[0], 4'd2});
                clk_stop_i = 1'b1;
                tick();
                check("R4 no suspend while awake", int'(phy_suspend_o), 0);
                send_hs(2'b11);
                check("R4 suspend in sleep", int'(phy_suspend_o), 1);
                check("R5 deep gating", int'(phy_deep_lp_o), (h == 1 && b == 1) ? 1 : 0);
                clk_stop_i = 1'b0;
                tick();
                check("R4 suspend needs clock stop", int'(phy_suspend_o), 0);
                check("R5 deep needs suspend", int'(phy_deep_lp_o), 0);
                clk_stop_i = 1'b1;
                tick();
                exit_event(h * 2 + b);
                check("R6 exit no resume", int'(resume_drive_o), 0);
                wake_tail("R6 exit event");
            end
        end

        // R6: remote wakeup wins over line activity in host role
        host_mode_i = 1'b1;
        write_thres(5'd3);
        send_hs(2'b11);
        @(negedge clk); rwk_wr_i = 1'b1; line_active_i = 1'b1;
        @(negedge clk); rwk_wr_i = 1'b0; line_active_i = 1'b0;
        check("R6 wakeup priority over line", int'(resume_drive_o), 0);
        wake_tail("R6 remote wakeup");

        // R8, R9: sweep all resume codes in host role
        for (int c = 0; c < 16; c++) begin
            int cnt;
            bit held;
            write_thres({c[0], 4'(c)});
            send_hs(2'b11);
            exit_event(0);
            if (c <= 12) begin
                cnt = 0;
                held = 1;
                while (resume_drive_o && cnt < 5000) begin
                    if (!sleep_sts_o) held = 0;
                    cnt++;
                    tick();
                end
                check("R8 resume length", cnt, (60 + 75 * c) * TPU);
                check("R8 sleep held during resume", int'(held), 1);
                check("R9 no error on valid code", int'(thres_err_o), 0);
                wake_tail("R8 resume exit");
            end else begin
                check("R9 no resume on invalid code", int'(resume_drive_o), 0);
                check("R9 error set", int'(thres_err_o), 1);
                wake_tail("R9 invalid exit");
                write_thres(5'd0);
                check("R9 error cleared by write", int'(thres_err_o), 0);
            end
        end

        // R10: ACK during resume does not re-enter sleep
        write_thres(5'd0);
        send_hs(2'b11);
        exit_event(0);
        check("R10 resume running", int'(resume_drive_o), 1);
        send_hs(2'b11);
        send_hs(2'b11);
        while (resume_drive_o) tick();
        wake_tail("R10 ignored ack");
        tick();
        check("R10 stays awake", int'(sleep_sts_o), 0);
        check("R10 no suspend", int'(phy_suspend_o), 0);

        // R12: bus reset and soft disconnect abort a long resume
        for (int k = 2; k < 4; k++) begin
            write_thres(5'd12);
            send_hs(2'b11);
            exit_event(0);
            repeat (10) tick();
            check("R12 resume running", int'(resume_drive_o), 1);
            exit_event(k);
            check("R12 resume aborted", int'(resume_drive_o), 0);
            wake_tail("R12 abort");
        end

        // R11: device role ignores the code, even an invalid one
        host_mode_i = 1'b0;
        write_thres(5'h1E);
        send_hs(2'b11);
        check("R11 no deep in device role", int'(phy_deep_lp_o), 0);
        exit_event(0);
        check("R11 no resume in device role", int'(resume_drive_o), 0);
        check("R11 no error in device role", int'(thres_err_o), 0);
        wake_tail("R11 device line");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule